// File: doc/BRIEF.md
# Segment-Buffered Non-Volatile Memory Bank

This block models one bank of a non-volatile main memory whose row buffer is deliberately small: it holds a single segment of a row rather than the whole row. An activate command carries the bank number, the row and the full column address. The bank decodes the row together with the upper column bits, senses only that segment out of the backing array and keeps it open. Column commands then read or write individual beats inside the open segment through a prefetch register, and several of them may follow one activation.

Reading the array leaves its cells intact. The bank therefore has no restore write-back after sensing, no refresh logic and no precharge command, and a miss goes straight to the next activation. The only write-back happens when the open segment has been modified by a column write: it is copied back to its home location before the next segment is sensed. While the array is being accessed the bank reports busy and drops every command it sees. A column command that does not fall inside the open segment is reported as a protocol error and has no other effect.

Top module: `psb_bank`

## Requirements
- R1: During and right after reset, busy, rd_valid and proto_err are low, and hit is low for every address because no segment is open.
- R2: An activate opens the segment made of row cmd_row and segment index cmd_col / SEG_BEATS. Afterwards hit is high for every column of that segment in that row and low for columns of any other segment.
- R3: An activate accepted while the open segment is clean keeps busy high for exactly RD_LAT cycles, with no precharge or restore phase before the sensing.
- R4: An activate accepted while the open segment is dirty keeps busy high for WR_LAT + RD_LAT cycles. Data written into the old segment is found again when that segment is reopened later.
- R5: A read column command that hits returns beat cmd_col % SEG_BEATS of the open segment on rd_data, with rd_valid high for one cycle. rd_valid rises CAS_LAT clock edges after the edge that accepts the command, counting that edge as the first.
- R6: Any number of consecutive read commands to the open segment are served without a new activation, and every beat of the segment can be read.
- R7: A write column command that hits replaces the addressed beat in the buffer and marks the segment dirty. A later read of that beat returns the new data.
- R8: A column command issued when no segment is open, or to a segment other than the open one, raises proto_err for one cycle starting at the next edge. It produces no rd_valid and changes no buffer data.
- R9: While busy is high, every command is ignored: it raises no proto_err, does not change which segment ends up open and does not mark the buffer dirty.
- R10: A command whose cmd_bank differs from BANK_ID is ignored. The bank stays idle, the open segment is unchanged, and neither rd_valid nor proto_err is raised.
- R11: After reset, array word i holds {16'hC0DE, i[15:0], ~i[15:0], 16'h5A5A}, where i = row * 2^COL_W + column. Sensing does not change the array, so a segment reopened without being written returns the same words. The command codes are 0 no-op, 1 activate, 2 read and 3 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Command code: 0 no-op, 1 activate, 2 read, 3 write |
| cmd_bank | input | BANK_W | Target bank of the command |
| cmd_row | input | ROW_W | Row address |
| cmd_col | input | COL_W | Column beat address (segment index in the upper bits) |
| cmd_wdata | input | DATA_W | Beat data for a write command |
| busy | output | 1 | Array access in progress; commands are dropped |
| hit | output | 1 | The address on cmd_row/cmd_col lies in the open segment |
| rd_valid | output | 1 | One-cycle strobe for read data |
| rd_data | output | DATA_W | Read beat |
| proto_err | output | 1 | One-cycle flag for a column command that missed |

## Verification
The assertions assume that the command inputs are stable across each rising edge and that a reset precedes all traffic. The bench meets this by changing cmd_* only on falling edges and by holding cmd_valid high for exactly one edge per command. Commands aimed at a busy bank are legal input and are checked as ignored. The only overlapping stimulus is sent deliberately during sensing, to exercise R9. Every other activation is followed by a wait until busy falls before the next command is sent.

// File: rtl/psb_pkg.sv
package psb_pkg;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_ACT = 2'd1,
    OP_RD  = 2'd2,
    OP_WR  = 2'd3
  } psb_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_SENSE = 2'd2
  } psb_state_e;

  // segment index of a column beat address
  function automatic int unsigned seg_of(int unsigned col, int unsigned seg_beats);
    return col / seg_beats;
  endfunction

  // beat position inside its segment
  function automatic int unsigned beat_of(int unsigned col, int unsigned seg_beats);
    return col % seg_beats;
  endfunction

  // power-on content of array word idx
  function automatic logic [63:0] fill_word(int unsigned idx);
    logic [15:0] lo;
    lo = idx[15:0];
    return {16'hC0DE, lo, ~lo, 16'h5A5A};
  endfunction

endpackage

// File: rtl/psb_array.sv
module psb_array #(
  parameter int ROW_W     = 4,
  parameter int COL_W     = 5,
  parameter int DATA_W    = 64,
  parameter int SEG_BEATS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROW_W-1:0]  rd_row,
  input  logic [COL_W-1:0]  rd_seg,
  output logic [DATA_W-1:0] rd_words [SEG_BEATS],
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [COL_W-1:0]  wr_seg,
  input  logic [DATA_W-1:0] wr_words [SEG_BEATS]
);
  localparam int AW    = ROW_W + COL_W;
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     rd_base;
  logic [AW-1:0]     wr_base;

  function automatic logic [AW-1:0] seg_base(logic [ROW_W-1:0] row, logic [COL_W-1:0] seg);
    return {row, {COL_W{1'b0}}} + AW'(seg) * AW'(SEG_BEATS);
  endfunction

  assign rd_base = seg_base(rd_row, rd_seg);
  assign wr_base = seg_base(wr_row, wr_seg);

  for (genvar g = 0; g < SEG_BEATS; g++) begin : g_rd
    assign rd_words[g] = mem[rd_base + AW'(g)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[AW'(i)] <= DATA_W'(psb_pkg::fill_word(i));
    end else if (wr_en) begin
      for (int i = 0; i < SEG_BEATS; i++) mem[wr_base + AW'(i)] <= wr_words[i];
    end
  end
endmodule

// File: rtl/psb_seq.sv
module psb_seq #(
  parameter int RD_LAT = 4,
  parameter int WR_LAT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_go,
  input  logic dirty,
  output logic busy,
  output logic in_wb,
  output logic wb_fire,
  output logic load_fire
);
  import psb_pkg::*;
  localparam int MAXL = (RD_LAT > WR_LAT) ? RD_LAT : WR_LAT;
  localparam int CW   = $clog2(MAXL + 1);

  psb_state_e    state_q;
  logic [CW-1:0] cnt_q;

  assign busy      = (state_q != ST_IDLE);
  assign in_wb     = (state_q == ST_WBACK);
  assign wb_fire   = in_wb && (cnt_q == '0);
  assign load_fire = (state_q == ST_SENSE) && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (act_go) begin
          state_q <= dirty ? ST_WBACK : ST_SENSE;
          cnt_q   <= dirty ? CW'(WR_LAT - 1) : CW'(RD_LAT - 1);
        end
        ST_WBACK: if (cnt_q == '0) begin
          state_q <= ST_SENSE;
          cnt_q   <= CW'(RD_LAT - 1);
        end else cnt_q <= cnt_q - 1'b1;
        ST_SENSE: if (cnt_q == '0) state_q <= ST_IDLE;
                  else cnt_q <= cnt_q - 1'b1;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/psb_rd_pipe.sv
module psb_rd_pipe #(
  parameter int DATA_W = 64,
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data
);
  logic              v_q [STAGES];
  logic [DATA_W-1:0] d_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) begin
        v_q[k] <= 1'b0;
        d_q[k] <= '0;
      end
    end else begin
      v_q[0] <= in_vld;          // stage 0 is the prefetch register
      if (in_vld) d_q[0] <= in_data;
      for (int k = 1; k < STAGES; k++) begin
        v_q[k] <= v_q[k-1];
        d_q[k] <= d_q[k-1];
      end
    end
  end

  assign out_vld  = v_q[STAGES-1];
  assign out_data = d_q[STAGES-1];
endmodule

// File: rtl/psb_bank.sv
module psb_bank #(
  parameter int ROW_W     = 4,
  parameter int COL_W     = 5,
  parameter int DATA_W    = 64,
  parameter int SEG_BEATS = 8,
  parameter int BANK_W    = 2,
  parameter int BANK_ID   = 0,
  parameter int RD_LAT    = 4,
  parameter int WR_LAT    = 6,
  parameter int CAS_LAT   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              hit,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              proto_err
);
  import psb_pkg::*;
  localparam int BW = (SEG_BEATS > 1) ? $clog2(SEG_BEATS) : 1;

  // named internal events, observed by the bound checker
  logic act_go, cas_rd_go, cas_wr_go, cas_bad;
  logic in_wb, wb_fire, load_fire;
  logic valid_q, dirty_q;

  logic              req;
  logic [COL_W-1:0]  req_seg;
  logic [BW-1:0]     req_beat;
  logic [ROW_W-1:0]  tag_row_q, pend_row_q;
  logic [COL_W-1:0]  tag_seg_q, pend_seg_q;
  logic [DATA_W-1:0] seg_buf [SEG_BEATS];
  logic [DATA_W-1:0] arr_words [SEG_BEATS];

  assign req_seg  = COL_W'(seg_of(int'(cmd_col), SEG_BEATS));
  assign req_beat = BW'(beat_of(int'(cmd_col), SEG_BEATS));
  assign hit      = valid_q && (tag_row_q == cmd_row) && (tag_seg_q == req_seg);

  assign req       = cmd_valid && !busy && (cmd_bank == BANK_W'(BANK_ID));
  assign act_go    = req && (cmd_op == OP_ACT);
  assign cas_rd_go = req && (cmd_op == OP_RD) && hit;
  assign cas_wr_go = req && (cmd_op == OP_WR) && hit;
  assign cas_bad   = req && ((cmd_op == OP_RD) || (cmd_op == OP_WR)) && !hit;

  psb_seq #(.RD_LAT(RD_LAT), .WR_LAT(WR_LAT)) i_seq (
    .clk(clk), .rst_n(rst_n), .act_go(act_go), .dirty(dirty_q),
    .busy(busy), .in_wb(in_wb), .wb_fire(wb_fire), .load_fire(load_fire)
  );

  psb_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .SEG_BEATS(SEG_BEATS)) i_array (
    .clk(clk), .rst_n(rst_n),
    .rd_row(pend_row_q), .rd_seg(pend_seg_q), .rd_words(arr_words),
    .wr_en(wb_fire), .wr_row(tag_row_q), .wr_seg(tag_seg_q), .wr_words(seg_buf)
  );

  psb_rd_pipe #(.DATA_W(DATA_W), .STAGES(CAS_LAT)) i_rd_pipe (
    .clk(clk), .rst_n(rst_n), .in_vld(cas_rd_go), .in_data(seg_buf[req_beat]),
    .out_vld(rd_valid), .out_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q    <= 1'b0;
      dirty_q    <= 1'b0;
      tag_row_q  <= '0;
      tag_seg_q  <= '0;
      pend_row_q <= '0;
      pend_seg_q <= '0;
      proto_err  <= 1'b0;
      for (int i = 0; i < SEG_BEATS; i++) seg_buf[i] <= '0;
    end else begin
      proto_err <= cas_bad;
      if (act_go) begin
        pend_row_q <= cmd_row;
        pend_seg_q <= req_seg;
      end
      if (load_fire) begin
        for (int i = 0; i < SEG_BEATS; i++) seg_buf[i] <= arr_words[i];
        tag_row_q <= pend_row_q;
        tag_seg_q <= pend_seg_q;
        valid_q   <= 1'b1;
        dirty_q   <= 1'b0;
      end else if (cas_wr_go) begin
        seg_buf[req_beat] <= cmd_wdata;
        dirty_q           <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/psb_bank_chk.sv
module psb_bank_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic act_go,
  input logic cas_wr_go,
  input logic cas_bad,
  input logic in_wb,
  input logic load_fire,
  input logic valid_q,
  input logic dirty_q,
  input logic proto_err
);
  p_act_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |=> busy);

  p_clean_no_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_go && !dirty_q) |=> !in_wb);

  p_dirty_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_go && dirty_q) |=> in_wb);

  p_load_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> (valid_q && !dirty_q));

  p_write_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cas_wr_go |=> dirty_q);

  p_err_after_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cas_bad |=> proto_err);

  p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(cas_bad));

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load_fire) |=> ($stable(dirty_q) && $stable(valid_q)));
endmodule

bind psb_bank psb_bank_chk i_psb_bank_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .act_go(act_go),
  .cas_wr_go(cas_wr_go), .cas_bad(cas_bad), .in_wb(in_wb),
  .load_fire(load_fire), .valid_q(valid_q), .dirty_q(dirty_q),
  .proto_err(proto_err)
);

// File: tb/test_psb_bank.sv
module test_psb_bank;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 4, COL_W = 5, DATA_W = 64, SEG_BEATS = 8;
  localparam int BANK_W = 2, BANK_ID = 1;
  localparam int RD_LAT = 4, WR_LAT = 6, CAS_LAT = 3;
  localparam int NVEC = 6;
  // {row, col, probe_col, probe_hit}
  localparam logic [14:0] VEC [NVEC] = '{
    {4'd3,  5'd5,  5'd2,  1'b1},
    {4'd3,  5'd9,  5'd20, 1'b0},
    {4'd0,  5'd0,  5'd7,  1'b1},
    {4'd15, 5'd31, 5'd24, 1'b1},
    {4'd7,  5'd16, 5'd15, 1'b0},
    {4'd9,  5'd12, 5'd8,  1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [BANK_W-1:0] cmd_bank = BANK_W'(BANK_ID);
  logic [ROW_W-1:0] cmd_row = '0;
  logic [COL_W-1:0] cmd_col = '0;
  logic [DATA_W-1:0] cmd_wdata = '0;
  logic busy, hit, rd_valid, proto_err;
  logic [DATA_W-1:0] rd_data;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psb_bank #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .SEG_BEATS(SEG_BEATS),
             .BANK_W(BANK_W), .BANK_ID(BANK_ID), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT),
             .CAS_LAT(CAS_LAT)) i_psb_bank (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_wdata(cmd_wdata),
    .busy(busy), .hit(hit), .rd_valid(rd_valid), .rd_data(rd_data), .proto_err(proto_err)
  );

  function automatic logic [63:0] exp_word(int r, int c);
    int i;
    i = r * 32 + c;
    return {16'hC0DE, i[15:0], 16'hFFFF - i[15:0], 16'h5A5A};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] op, int bank, int row, int col, logic [63:0] wd,
                       output logic err);
    @(negedge clk);
    cmd_op = op; cmd_bank = BANK_W'(bank); cmd_row = ROW_W'(row);
    cmd_col = COL_W'(col); cmd_wdata = wd; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    err = proto_err;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic act(int row, int col, output int n);
    logic e;
    drive(2'd1, BANK_ID, row, col, '0, e);
    wait_idle(n);
  endtask

  task automatic rd(int row, int col, output logic [63:0] d, output logic v, output logic e);
    drive(2'd2, BANK_ID, row, col, '0, e);
    repeat (CAS_LAT - 1) @(negedge clk);
    v = rd_valid; d = rd_data;
  endtask

  task automatic probe(int row, int col, output logic h);
    cmd_row = ROW_W'(row); cmd_col = COL_W'(col);
    #1 h = hit;
  endtask

  initial begin
    logic [63:0] d;
    logic v, e, h;
    int n;
    repeat (3) @(negedge clk);
    probe(3, 5, h);
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 rd_valid", 64'(rd_valid), 64'd0);
    check("R1 proto_err", 64'(proto_err), 64'd0);
    check("R1 hit", 64'(h), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: column command before any activation
    rd(3, 5, d, v, e);
    check("R8 err no open", 64'(e), 64'd1);
    check("R8 no rd_valid", 64'(v), 64'd0);

    // vector walk: R2 R3 R5 R11
    for (int k = 0; k < NVEC; k++) begin
      int r, c, pc;
      logic ph;
      r = int'(VEC[k][14:11]); c = int'(VEC[k][10:6]);
      pc = int'(VEC[k][5:1]); ph = VEC[k][0];
      act(r, c, n);
      check("R3 sense cycles", 64'(n), 64'(RD_LAT));
      probe(r, c, h);
      check("R2 hit own", 64'(h), 64'd1);
      probe(r, pc, h);
      check("R2 hit probe", 64'(h), 64'(ph));
      rd(r, c, d, v, e);
      check("R5 rd_valid", 64'(v), 64'd1);
      check("R11 R5 data", d, exp_word(r, c));
    end

    // R6: every beat of open segment row 9 seg 1
    for (int b = 0; b < SEG_BEATS; b++) begin
      rd(9, 8 + b, d, v, e);
      check("R6 burst valid", 64'(v), 64'd1);
      check("R6 burst data", d, exp_word(9, 8 + b));
    end

    // R7: write then read back
    drive(2'd3, BANK_ID, 9, 10, 64'hDEAD_BEEF_0123_4567, e);
    check("R7 write no err", 64'(e), 64'd0);
    rd(9, 10, d, v, e);
    check("R7 readback", d, 64'hDEAD_BEEF_0123_4567);
    rd(9, 11, d, v, e);
    check("R7 neighbour", d, exp_word(9, 11));

    // R4: dirty write-back before the next segment
    act(2, 0, n);
    check("R4 wb+sense cycles", 64'(n), 64'(WR_LAT + RD_LAT));
    rd(2, 3, d, v, e);
    check("R11 new seg", d, exp_word(2, 3));
    act(9, 12, n);
    check("R3 clean again", 64'(n), 64'(RD_LAT));
    rd(9, 10, d, v, e);
    check("R4 persisted", d, 64'hDEAD_BEEF_0123_4567);
    rd(9, 9, d, v, e);
    check("R11 nondestructive", d, exp_word(9, 9));

    // R8: misses leave the buffer untouched
    drive(2'd3, BANK_ID, 9, 2, 64'h1111_2222_3333_4444, e);
    check("R8 write miss err", 64'(e), 64'd1);
    rd(9, 10, d, v, e);
    check("R8 buffer intact", d, 64'hDEAD_BEEF_0123_4567);
    rd(4, 10, d, v, e);
    check("R8 read miss err", 64'(e), 64'd1);
    check("R8 read miss no data", 64'(v), 64'd0);

    // R9: commands during sensing are dropped
    drive(2'd1, BANK_ID, 5, 8, '0, e);
    drive(2'd3, BANK_ID, 9, 10, 64'hBAD0_BAD0_BAD0_BAD0, e);
    check("R9 no err when busy", 64'(e), 64'd0);
    drive(2'd1, BANK_ID, 6, 0, '0, e);
    wait_idle(n);
    probe(5, 9, h);
    check("R9 first act kept", 64'(h), 64'd1);
    probe(6, 0, h);
    check("R9 second act dropped", 64'(h), 64'd0);
    rd(5, 8, d, v, e);
    check("R9 data", d, exp_word(5, 8));
    act(9, 12, n);
    check("R9 not dirtied", 64'(n), 64'(RD_LAT));
    rd(9, 10, d, v, e);
    check("R9 write ignored", d, 64'hDEAD_BEEF_0123_4567);

    // R10: foreign bank
    drive(2'd1, 2, 0, 0, '0, e);
    check("R10 stays idle", 64'(busy), 64'd0);
    probe(0, 0, h);
    check("R10 no open", 64'(h), 64'd0);
    probe(9, 12, h);
    check("R10 open kept", 64'(h), 64'd1);
    drive(2'd2, 0, 4, 4, '0, e);
    check("R10 no err", 64'(e), 64'd0);
    repeat (CAS_LAT - 1) @(negedge clk);
    check("R10 no rd_valid", 64'(rd_valid), 64'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule